// File: doc/BRIEF.md
# Multi-Lane PCM Serial Audio Receiver

This block deserialises PCM audio arriving on three data lanes that share one bit clock and one word clock. Each lane carries a stereo pair, so the block delivers six channels. It runs entirely in the bit-clock domain: the bit clock is the block clock, and the serial data and the word clock are sampled on its rising edge, most significant bit first.

A static configuration selects the framing, the word length and the output alignment. The framing is I2S, left-justified or right-justified. The word length is 16, 20, 24 or 32 bits. A sample is presented either sign-extended or left-aligned in a 32-bit field. When both halves of a stereo frame have been received, the block updates all six parallel outputs together and raises a single-cycle valid strobe. The word-clock transition is the only frame reference, so any frame length is accepted as long as each half-frame is long enough for the chosen framing and word length.

Top module: `pcm_multilane_rx`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `valid_o` is 0 and every bit of `left_o` and `right_o` is 0 after that edge.
- R2: In left-justified framing (`cfg_fmt_i` = 1), the MSB of a word is the bit sampled on the first edge at which the sampled word clock differs from its previous value, and the following bits continue toward the LSB.
- R3: In I2S framing (`cfg_fmt_i` = 0), the MSB is the bit sampled one edge after the word-clock change, and the bit sampled on the change edge is ignored.
- R4: In right-justified framing (`cfg_fmt_i` = 2), the LSB is the last bit sampled before the next word-clock change, and all earlier bits of the half-frame beyond the word length are ignored.
- R5: In I2S framing a low word clock marks the left channel. In both justified framings a high word clock marks the left channel. The left half precedes the right half of a frame.
- R6: `cfg_wlen_i` codes 0, 1, 2 and 3 select word lengths of 16, 20, 24 and 32 bits.
- R7: With `cfg_left_align_i` = 0 a sample is sign-extended from its MSB to 32 bits. With `cfg_left_align_i` = 1 it sits in the upper bits, with zeros below. Between strobes the outputs hold their values.
- R8: `valid_o` is high for exactly one cycle per complete frame. It rises in the cycle after the edge that samples the word-clock change ending the right half, and only after such an edge.
- R9: In I2S and left-justified framing, bits of a half-frame beyond the configured word length are discarded.
- R10: The three lanes are decoded independently with identical timing. Lane k occupies bits [32k+31:32k] of `left_o` and `right_o`.
- R11: The half-frame in progress when reset is released is discarded, and no strobe is produced for a right word that had no preceding left word.
- R12: `cfg_fmt_i` code 3 behaves as left-justified framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all sampling on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lrck_i | input | 1 | Word clock, one period per stereo frame |
| sdata_i | input | 3 | Serial data, one bit per lane |
| cfg_fmt_i | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 as 1 |
| cfg_wlen_i | input | 2 | Word length: 0=16, 1=20, 2=24, 3=32 bits |
| cfg_left_align_i | input | 1 | 1 left-aligns samples, 0 sign-extends them |
| left_o | output | 96 | Left samples, lane k at bits [32k+31:32k] |
| right_o | output | 96 | Right samples, lane k at bits [32k+31:32k] |
| valid_o | output | 1 | One-cycle strobe when a new frame is on the outputs |

## Verification
The checker watches, on every cycle, that the strobe never lasts two cycles and follows only a word-clock change that opens a left half. It also checks that the outputs never move without a strobe, that reset clears them, and that 16-bit samples carry a correct sign extension or zero tail. Where each bit sits inside a half-frame under the three framings and four lengths can only be shown by the bench's scenarios. The same holds for discarding surplus bits, for lane independence and for dropping the partial half after reset. The bench drives known words with filler bits set to one and compares every strobe against its queue.

// File: rtl/pcm_rx_pkg.sv
// Shared definitions for the multi-lane PCM receiver.
// Assumes samples never exceed SAMPLE_W bits.
package pcm_rx_pkg;

    localparam int SAMPLE_W = 32;
    localparam int LEN_W    = 6;

    typedef enum logic [1:0] {
        FMT_I2S   = 2'd0,
        FMT_LEFT  = 2'd1,
        FMT_RIGHT = 2'd2,
        FMT_RSVD  = 2'd3
    } fmt_e;

    // Decode the word-length code into a bit count.
    function automatic logic [LEN_W-1:0] wlen_bits(input logic [1:0] code);
        case (code)
            2'd0:    return LEN_W'(16);
            2'd1:    return LEN_W'(20);
            2'd2:    return LEN_W'(24);
            default: return LEN_W'(32);
        endcase
    endfunction

    // Word-clock level that marks the left channel for a framing.
    function automatic logic left_level(input logic [1:0] fmt);
        return (fmt == FMT_I2S) ? 1'b0 : 1'b1;
    endfunction

    // Place the low 'bits' of raw into a full-width sample.
    function automatic logic [SAMPLE_W-1:0] shape_word(
        input logic [SAMPLE_W-1:0] raw,
        input logic [LEN_W-1:0]    bits,
        input logic                left_al
    );
        logic [SAMPLE_W-1:0] mask;
        logic [SAMPLE_W-1:0] val;
        mask = (bits >= LEN_W'(SAMPLE_W)) ? '1
                                          : ((SAMPLE_W'(1) << bits) - SAMPLE_W'(1));
        val  = raw & mask;
        if (left_al)
            return val << (LEN_W'(SAMPLE_W) - bits);
        else if (val[bits - LEN_W'(1)])
            return val | ~mask;
        else
            return val;
    endfunction

endpackage

// File: rtl/pcm_rx_frame_ctrl.sv
// Frame sequencer shared by all lanes.
// It finds word-clock changes, counts bit positions in the current half,
// decides which bits enter the lane shifters, and marks the ends of
// left and right words.
// Assumes the word clock is sampled on the same edge as the data.
module pcm_rx_frame_ctrl
    import pcm_rx_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lrck_i,
    input  logic [1:0]       fmt_i,
    input  logic [LEN_W-1:0] wbits_i,
    output logic             restart_o,
    output logic             shift_en_o,
    output logic             latch_left_o,
    output logic             frame_done_o,
    output logic             valid_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam int               XW      = CNT_W + 1;

    logic             lr_q;
    logic             lr_seen;
    logic             in_frame;
    logic             have_left;
    logic [CNT_W-1:0] cnt;
    logic             valid_q;

    logic             edge_c;
    logic [CNT_W-1:0] idx;
    logic [XW-1:0]    win_lo;
    logic [XW-1:0]    win_hi;
    logic             word_done;
    logic             ended_left;

    // Detect a word-clock change and compute this bit's position.
    always_comb begin
        edge_c = lr_seen && (lrck_i != lr_q);
        idx    = edge_c ? '0 : cnt;
    end

    // Choose whether the current bit belongs to the word window.
    always_comb begin
        win_lo = (fmt_i == FMT_I2S) ? XW'(1) : XW'(0);
        win_hi = win_lo + XW'(wbits_i);
        if (fmt_i == FMT_RIGHT)
            shift_en_o = 1'b1;
        else
            shift_en_o = ({1'b0, idx} >= win_lo) && ({1'b0, idx} < win_hi);
    end

    // Classify the half that ends at this change.
    always_comb begin
        ended_left   = (lr_q == left_level(fmt_i));
        word_done    = edge_c && in_frame;
        latch_left_o = word_done && ended_left;
        frame_done_o = word_done && !ended_left && have_left;
        restart_o    = edge_c;
    end

    // Track word-clock history, bit count and frame pairing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_q      <= 1'b0;
            lr_seen   <= 1'b0;
            in_frame  <= 1'b0;
            have_left <= 1'b0;
            cnt       <= '0;
            valid_q   <= 1'b0;
        end else begin
            lr_q    <= lrck_i;
            lr_seen <= 1'b1;
            valid_q <= frame_done_o;
            if (edge_c)
                in_frame <= 1'b1;
            if (edge_c)
                cnt <= CNT_W'(1);
            else if (cnt != CNT_MAX)
                cnt <= cnt + CNT_W'(1);
            if (latch_left_o)
                have_left <= 1'b1;
            else if (word_done)
                have_left <= 1'b0;
        end
    end

    assign valid_o = valid_q;

endmodule

// File: rtl/pcm_rx_lane.sv
// One data lane: shifts in serial bits, keeps the left word until its
// right partner completes, then updates both outputs together.
// Assumes the control strobes come from pcm_rx_frame_ctrl in the same cycle.
module pcm_rx_lane
    import pcm_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sdata_i,
    input  logic                restart_i,
    input  logic                shift_en_i,
    input  logic                latch_left_i,
    input  logic                frame_done_i,
    input  logic [LEN_W-1:0]    wbits_i,
    input  logic                left_align_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o
);

    logic [SAMPLE_W-1:0] shreg;
    logic [SAMPLE_W-1:0] left_hold;
    logic [SAMPLE_W-1:0] finished;

    // Format the word that the shifter holds at a half boundary.
    always_comb begin
        finished = shape_word(shreg, wbits_i, left_align_i);
    end

    // Shift register: restart at a half boundary, else accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (restart_i)
            shreg <= shift_en_i ? SAMPLE_W'(sdata_i) : '0;
        else if (shift_en_i)
            shreg <= {shreg[SAMPLE_W-2:0], sdata_i};
    end

    // Hold the left word, then publish the pair when the right word ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_hold <= '0;
            left_o    <= '0;
            right_o   <= '0;
        end else begin
            if (latch_left_i)
                left_hold <= finished;
            if (frame_done_i) begin
                left_o  <= left_hold;
                right_o <= finished;
            end
        end
    end

endmodule

// File: rtl/pcm_multilane_rx.sv
// Top of the multi-lane PCM receiver: one frame sequencer drives
// LANES identical lane decoders.
// Assumes static configuration while out of reset and a bit clock as clk.
module pcm_multilane_rx
    import pcm_rx_pkg::*;
#(
    parameter int LANES = 3,
    parameter int CNT_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      lrck_i,
    input  logic [LANES-1:0]          sdata_i,
    input  logic [1:0]                cfg_fmt_i,
    input  logic [1:0]                cfg_wlen_i,
    input  logic                      cfg_left_align_i,
    output logic [LANES*SAMPLE_W-1:0] left_o,
    output logic [LANES*SAMPLE_W-1:0] right_o,
    output logic                      valid_o
);

    logic [LEN_W-1:0] wbits;
    logic             restart;
    logic             shift_en;
    logic             latch_left;
    logic             frame_done;

    // Decode the word length once for all lanes.
    always_comb begin
        wbits = wlen_bits(cfg_wlen_i);
    end

    pcm_rx_frame_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .lrck_i       (lrck_i),
        .fmt_i        (cfg_fmt_i),
        .wbits_i      (wbits),
        .restart_o    (restart),
        .shift_en_o   (shift_en),
        .latch_left_o (latch_left),
        .frame_done_o (frame_done),
        .valid_o      (valid_o)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        pcm_rx_lane lane_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .sdata_i      (sdata_i[k]),
            .restart_i    (restart),
            .shift_en_i   (shift_en),
            .latch_left_i (latch_left),
            .frame_done_i (frame_done),
            .wbits_i      (wbits),
            .left_align_i (cfg_left_align_i),
            .left_o       (left_o[k*SAMPLE_W +: SAMPLE_W]),
            .right_o      (right_o[k*SAMPLE_W +: SAMPLE_W])
        );
    end

endmodule

// File: rtl/pcm_multilane_rx_chk.sv
// Property checker for pcm_multilane_rx, bound to every instance.
// Assumes the default lane layout of 32-bit samples.
module pcm_multilane_rx_chk
    import pcm_rx_pkg::*;
#(
    parameter int LANES = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      lrck_i,
    input logic [1:0]                cfg_fmt_i,
    input logic [1:0]                cfg_wlen_i,
    input logic                      cfg_left_align_i,
    input logic [LANES*SAMPLE_W-1:0] left_o,
    input logic [LANES*SAMPLE_W-1:0] right_o,
    input logic                      valid_o
);

    localparam logic [LANES*SAMPLE_W-1:0] LOW16 = {LANES{32'h0000_FFFF}};

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && left_o == '0 && right_o == '0));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r8_after_wclk_change: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(lrck_i) != $past(lrck_i, 2)));

    a_r5_strobe_opens_left: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(lrck_i) == left_level(cfg_fmt_i)));

    a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

    a_r7_left_align_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && cfg_left_align_i && cfg_wlen_i == 2'd0)
            |-> ((left_o & LOW16) == '0 && (right_o & LOW16) == '0));

    a_r7_sign_extend: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !cfg_left_align_i && cfg_wlen_i == 2'd0)
            |-> (left_o[31:16] == {16{left_o[15]}}));

endmodule

bind pcm_multilane_rx pcm_multilane_rx_chk #(.LANES(LANES)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .lrck_i           (lrck_i),
    .cfg_fmt_i        (cfg_fmt_i),
    .cfg_wlen_i       (cfg_wlen_i),
    .cfg_left_align_i (cfg_left_align_i),
    .left_o           (left_o),
    .right_o          (right_o),
    .valid_o          (valid_o)
);

// File: tb/pcm_multilane_rx_tb_top.sv
module pcm_multilane_rx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 3;

    typedef struct packed {
        logic [LANES-1:0][31:0] l;
        logic [LANES-1:0][31:0] r;
    } frame_t;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  lrck = 1'b0;
    logic [LANES-1:0]      sdata = '0;
    logic [1:0]            fmt = 2'd1;
    logic [1:0]            wcode = 2'd0;
    logic                  lal = 1'b0;
    logic [LANES*32-1:0]   left_o;
    logic [LANES*32-1:0]   right_o;
    logic                  valid_o;

    frame_t exp_q[$];
    string  tag = "R1";
    int     total = 0;
    int     bad = 0;
    logic   prev_valid = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_multilane_rx dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .lrck_i           (lrck),
        .sdata_i          (sdata),
        .cfg_fmt_i        (fmt),
        .cfg_wlen_i       (wcode),
        .cfg_left_align_i (lal),
        .left_o           (left_o),
        .right_o          (right_o),
        .valid_o          (valid_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int bits_of(input logic [1:0] c);
        int n;
        case (c)
            2'd0: n = 16;
            2'd1: n = 20;
            2'd2: n = 24;
            default: n = 32;
        endcase
        return n;
    endfunction

    function automatic logic [31:0] expect_word(input logic [31:0] w, input int n, input logic al);
        logic [63:0] m;
        logic [63:0] t;
        m = (64'd1 << n) - 64'd1;
        t = {32'd0, w} & m;
        if (al) return 32'(t << (32 - n));
        if (t[n-1]) return 32'(t | ~m);
        return 32'(t);
    endfunction

    function automatic logic lvl_left(input logic [1:0] f);
        return (f == 2'd0) ? 1'b0 : 1'b1;
    endfunction

    // Drive one half-frame of H bits at word-clock level lv.
    task automatic drive_half(input logic lv, input logic [LANES-1:0][31:0] w, input int h);
        int n;
        n = bits_of(wcode);
        for (int i = 0; i < h; i++) begin
            @(negedge clk);
            lrck = lv;
            for (int k = 0; k < LANES; k++) begin
                if (fmt == 2'd0)
                    sdata[k] = (i >= 1 && i <= n) ? w[k][n-i] : 1'b1;
                else if (fmt == 2'd2)
                    sdata[k] = (i >= h - n) ? w[k][h-1-i] : 1'b1;
                else
                    sdata[k] = (i < n) ? w[k][n-1-i] : 1'b1;
            end
        end
    endtask

    task automatic run_scn(input string t, input logic [1:0] f, input logic [1:0] wc,
                           input logic al, input int h, input int nfr);
        logic [LANES-1:0][31:0] lw;
        logic [LANES-1:0][31:0] rw;
        frame_t e;
        int n;
        @(negedge clk);
        rst_n = 1'b0;
        tag = t;
        fmt = f;
        wcode = wc;
        lal = al;
        lrck = ~lvl_left(f);
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0, "R1", "valid in reset", 32'(valid_o), 32'd0);
        check(left_o == '0 && right_o == '0, "R1", "outputs in reset",
              left_o[31:0] | right_o[31:0], 32'd0);
        rst_n = 1'b1;
        n = bits_of(wc);
        // R11: a partial half with random content precedes the first frame.
        for (int k = 0; k < LANES; k++) rw[k] = $urandom;
        drive_half(~lvl_left(f), rw, 5);
        for (int fr = 0; fr < nfr; fr++) begin
            for (int k = 0; k < LANES; k++) begin
                lw[k] = $urandom;
                rw[k] = $urandom;
                e.l[k] = expect_word(lw[k], n, al);
                e.r[k] = expect_word(rw[k], n, al);
            end
            exp_q.push_back(e);
            drive_half(lvl_left(f), lw, h);
            drive_half(~lvl_left(f), rw, h);
        end
        rw = '0;
        drive_half(lvl_left(f), rw, 4);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R8", {t, " strobe count"}, 32'(exp_q.size()), 32'd0);
        exp_q.delete();
    endtask

    // Monitor: compares each strobe against the scoreboard queue.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && valid_o) begin
            check(!prev_valid, "R8", "strobe longer than one cycle", 32'd1, 32'd0);
            if (exp_q.size() == 0) begin
                check(1'b0, "R11", {tag, " unexpected strobe"}, 32'd1, 32'd0);
            end else begin
                frame_t e;
                e = exp_q.pop_front();
                for (int k = 0; k < LANES; k++) begin
                    check(left_o[k*32 +: 32] == e.l[k], tag, $sformatf("lane%0d left", k),
                          left_o[k*32 +: 32], e.l[k]);
                    check(right_o[k*32 +: 32] == e.r[k], tag, $sformatf("lane%0d right", k),
                          right_o[k*32 +: 32], e.r[k]);
                end
            end
        end
        prev_valid = valid_o;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        run_scn("R2 R5 R6 R7 R9 R10 left-justified 16b sign", 2'd1, 2'd0, 1'b0, 32, 3);
        run_scn("R2 R6 R7 R9 left-justified 24b aligned", 2'd1, 2'd2, 1'b1, 32, 3);
        run_scn("R2 R6 left-justified 32b", 2'd1, 2'd3, 1'b0, 32, 2);
        run_scn("R3 R5 R6 R9 R10 i2s 24b sign", 2'd0, 2'd2, 1'b0, 32, 3);
        run_scn("R3 R6 R7 i2s 20b aligned", 2'd0, 2'd1, 1'b1, 28, 3);
        run_scn("R3 R6 i2s 32b", 2'd0, 2'd3, 1'b0, 40, 2);
        run_scn("R4 R5 R6 R10 right-justified 20b", 2'd2, 2'd1, 1'b0, 32, 3);
        run_scn("R4 R7 right-justified 16b aligned", 2'd2, 2'd0, 1'b1, 24, 3);
        run_scn("R4 right-justified 32b", 2'd2, 2'd3, 1'b0, 32, 2);
        run_scn("R12 R11 reserved code as left-justified", 2'd3, 2'd0, 1'b0, 20, 3);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule